// File: doc/BRIEF.md
# Output-Compare Channel Bank

This block holds a small set of output-compare channels that watch a free-running time count supplied from outside. Each channel holds a compare value. When the count reaches that value on a cycle where the count advances, the channel raises its flag. Depending on its programmed mode, it also flips its output pin or drives a pulse that is high for one cycle. A flagged channel can request an interrupt, a DMA transfer, or both.

Each channel buffers its compare value twice. The first write after the channel is cleared arms the active match. A second write is parked until the active match fires, and it then takes over. This lets a service routine keep a periodic waveform, such as a once-per-second pulse, running without gaps: inside the handler it writes the value for the match after next. The intended setup sequence has three steps. First, clear the channel's mode, which empties both buffers. Next, write the first compare value. Finally, select the output mode.

All registers sit on one word-addressed bus with a write strobe and a combinational read port.

Top module: `ocmp_bank`

## Requirements
- R1: After reset every flag, pin, DMA request, the interrupt and the status word read 0.
- R2: Word address 0 is the status word. Word address 2+2n is the control word of channel n, and word address 3+2n reads back channel n's active compare value. The control word uses these bit positions: bit 0 DMA-request enable, bits 5:2 mode, bit 6 interrupt enable, bit 7 flag.
- R3: A match occurs when four conditions hold in one cycle: the tick input is high, the count equals the active compare value, that value is armed, and the mode is nonzero. The flag is then 1 from the next cycle. An equal count while tick is low has no effect.
- R4: Writing a control word with bit 7 set clears the flag. Writing bit 7 as 0 leaves the flag unchanged. If a match and a clearing write occur in the same cycle, the match wins.
- R5: In mode 0x5 the pin inverts on every match and holds its value between matches.
- R6: In mode 0xF the pin is high for exactly the one cycle after a match, and low otherwise.
- R7: A compare write to a channel with nothing armed arms that value. A compare write while a value is armed is held as pending, and it becomes the armed value when the armed match fires. An armed value with nothing pending fires only once.
- R8: Writing a control word with mode 0 has three effects: it drives the pin to 0, it discards the armed and pending compare values, and later matches are ignored while the mode stays 0.
- R9: The interrupt output is the OR over all channels of flag AND interrupt enable. DMA request n is flag n AND DMA-request enable n.
- R10: Bit n of the status word equals channel n's flag, and the bits above the channel count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| count | input | CW | Running time count |
| tick | input | 1 | High in cycles where count has advanced |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | CW | Register write data |
| bus_rdata | output | CW | Register read data for bus_addr |
| pin | output | NCH | Channel output waveforms |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | NCH | Per-channel DMA request |

## Verification
The bench runs the same program on every channel in turn, and checks that the other channels stay silent in the status word. It offers matches three ways: with tick low, at the pending value before the armed one, and at the armed value. This separates tick qualification from buffer ordering. The bench then repeats a match at a value that has already fired, which tells one-shot behaviour from a compare that stays live. The pulse, toggle and off modes are each driven through matches, and the enable bits are switched between runs. A wrong pin waveform, a misrouted interrupt, or a misrouted DMA request therefore shows up at the ports.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam logic [3:0] MODE_OFF    = 4'h0;
    localparam logic [3:0] MODE_TOGGLE = 4'h5;
    localparam logic [3:0] MODE_PULSE  = 4'hF;

    typedef struct packed {
        logic       flag;     // bit 7
        logic       irq_en;   // bit 6
        logic [3:0] mode;     // bits 5:2
        logic       rsv;      // bit 1
        logic       dreq_en;  // bit 0
    } ocmp_ctrl_t;

    function automatic logic [3:0] mode_of(input logic [7:0] w);
        return w[5:2];
    endfunction

endpackage

// File: rtl/ocmp_decode.sv
module ocmp_decode #(
    parameter int NCH = 4,
    parameter int AW  = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           we,
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] cmp_we,
    output logic           sel_status,
    output logic           sel_valid,
    output logic           sel_cmp,
    output logic [CHW-1:0] sel_ch
);
    localparam logic [AW-1:0] BASE  = AW'(2);
    localparam logic [AW-1:0] NCH_A = AW'(NCH);

    logic [AW-1:0] off;
    logic [AW-1:0] chan;

    assign off        = addr - BASE;
    assign chan       = {1'b0, off[AW-1:1]};
    assign sel_status = (addr == '0);
    assign sel_valid  = (addr >= BASE) && (chan < NCH_A);
    assign sel_cmp    = off[0];
    assign sel_ch     = CHW'(chan);

    for (genvar g = 0; g < NCH; g++) begin : g_strobe
        assign ctrl_we[g] = we && sel_valid && (chan == AW'(g)) && !off[0];
        assign cmp_we[g]  = we && sel_valid && (chan == AW'(g)) &&  off[0];
    end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic          cmp_we,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] count,
    input  logic          tick,
    output ocmp_ctrl_t    ctrl_o,
    output logic [CW-1:0] cmp_o,
    output logic          pin_o
);
    ocmp_ctrl_t    c_q;
    logic [CW-1:0] act_q, pend_q;
    logic          act_v, pend_v, pin_q;
    logic          hit;
    logic          off_wr;

    assign hit    = act_v && tick && (count == act_q) && (c_q.mode != MODE_OFF);
    assign off_wr = ctrl_we && (mode_of(wdata[7:0]) == MODE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q    <= '0;
            act_q  <= '0;
            pend_q <= '0;
            act_v  <= 1'b0;
            pend_v <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                c_q.dreq_en <= wdata[0];
                c_q.mode    <= mode_of(wdata[7:0]);
                c_q.irq_en  <= wdata[6];
            end
            if (hit)
                c_q.flag <= 1'b1;
            else if (ctrl_we && wdata[7])
                c_q.flag <= 1'b0;

            if (off_wr) begin
                act_v  <= 1'b0;
                pend_v <= 1'b0;
            end else begin
                if (hit) begin
                    if (pend_v) begin
                        act_q  <= pend_q;
                        pend_v <= 1'b0;
                    end else begin
                        act_v  <= 1'b0;
                    end
                end
                if (cmp_we) begin
                    if (!act_v || (hit && !pend_v)) begin
                        act_q <= wdata;
                        act_v <= 1'b1;
                    end else begin
                        pend_q <= wdata;
                        pend_v <= 1'b1;
                    end
                end
            end

            if (off_wr)
                pin_q <= 1'b0;
            else if (c_q.mode == MODE_PULSE)
                pin_q <= hit;
            else if (c_q.mode == MODE_TOGGLE && hit)
                pin_q <= ~pin_q;
        end
    end

    assign ctrl_o = c_q;
    assign cmp_o  = act_q;
    assign pin_o  = pin_q;

    // R3: a flag only rises after a qualified match
    a_r3_flag_from_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.flag) |-> $past(hit));

    // R5: between matches a toggling pin keeps its level
    a_r5_toggle_hold: assert property (@(posedge clk) disable iff (rst)
        (c_q.mode == MODE_TOGGLE && $past(c_q.mode) == MODE_TOGGLE && !$past(hit))
        |-> $stable(pin_q));

    // R6: in pulse mode a high pin always follows a match one cycle earlier
    a_r6_pulse_src: assert property (@(posedge clk) disable iff (rst)
        (c_q.mode == MODE_PULSE && $past(c_q.mode) == MODE_PULSE && pin_q)
        |-> $past(hit));

    // R7: a pending value never exists without an armed one
    a_r7_pend_needs_act: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> act_v);

    // R8: a channel in mode 0 keeps its pin low
    a_r8_off_pin_low: assert property (@(posedge clk) disable iff (rst)
        (c_q.mode == MODE_OFF) |-> !pin_q);
endmodule

// File: rtl/ocmp_bank.sv
module ocmp_bank
    import ocmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  count,
    input  logic           tick,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] pin,
    output logic           irq,
    output logic [NCH-1:0] dma_req
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] ctrl_we, cmp_we, flags, irq_vec;
    logic           sel_status, sel_valid, sel_cmp;
    logic [CHW-1:0] sel_ch;
    ocmp_ctrl_t     ctrl_a [NCH];
    logic [CW-1:0]  cmp_a  [NCH];

    ocmp_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .we(bus_we), .addr(bus_addr), .ctrl_we(ctrl_we), .cmp_we(cmp_we),
        .sel_status(sel_status), .sel_valid(sel_valid),
        .sel_cmp(sel_cmp), .sel_ch(sel_ch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ocmp_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst(rst), .ctrl_we(ctrl_we[g]), .cmp_we(cmp_we[g]),
            .wdata(bus_wdata), .count(count), .tick(tick),
            .ctrl_o(ctrl_a[g]), .cmp_o(cmp_a[g]), .pin_o(pin[g])
        );
        assign flags[g]   = ctrl_a[g].flag;
        assign irq_vec[g] = ctrl_a[g].flag & ctrl_a[g].irq_en;
        assign dma_req[g] = ctrl_a[g].flag & ctrl_a[g].dreq_en;
    end

    assign irq = |irq_vec;

    always_comb begin
        bus_rdata = '0;
        if (sel_status)
            bus_rdata[NCH-1:0] = flags;
        else if (sel_valid) begin
            if (sel_cmp)
                bus_rdata = cmp_a[sel_ch];
            else
                bus_rdata[7:0] = ctrl_a[sel_ch];
        end
    end

    // R9: an interrupt never stands without some flag raised
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    // R9: DMA requests come only from flagged channels
    a_r9_dma_subset: assert property (@(posedge clk) disable iff (rst)
        (dma_req & ~flags) == '0);
endmodule

// File: tb/sim_ocmp_bank.sv
module sim_ocmp_bank;
    localparam int NCH = 4;
    localparam int CW  = 32;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [CW-1:0]  count = '0;
    logic           tick = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [CW-1:0]  bus_wdata = '0;
    logic [CW-1:0]  bus_rdata;
    logic [NCH-1:0] pin, dma_req;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ocmp_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .count(count), .tick(tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin(pin), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    // one cycle with the given count; tk selects the tick level
    task automatic step(input logic [31:0] c, input logic tk);
        @(negedge clk);
        count = c; tick = tk;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(0, v);
        chk("R1 status", v, 0);
        chk("R1 pins", 32'(pin), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma", 32'(dma_req), 0);

        for (int ch = 0; ch < NCH; ch++) begin
            int ca = 2 + 2 * ch;
            int ma = 3 + 2 * ch;
            logic [31:0] a = 32'(100 * ch + 7);
            logic [31:0] b = a + 32'd40;
            logic [31:0] c = a + 32'd90;
            logic [31:0] bit_ch = 32'(1) << ch;

            // pulse mode, irq and dma enabled: 0x40 | (0xF<<2) | 0x1
            wr(ca, 32'h00);
            wr(ma, a);
            wr(ma, b);
            wr(ca, 32'h7D);
            rd(ca, v);
            chk("R2 ctrl readback", v, 32'h7D);
            rd(ma, v);
            chk("R7 first write armed", v, a);

            step(a, 1'b0);
            rd(0, v);
            chk("R3 no tick no match", v, 0);
            step(b, 1'b1);
            rd(0, v);
            chk("R7 pending not live", v, 0);

            @(negedge clk); count = a; tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            rd(0, v);
            chk("R10 status one bit", v, bit_ch);
            chk("R6 pulse high", 32'(pin), bit_ch);
            chk("R9 irq", 32'(irq), 1);
            chk("R9 dma", 32'(dma_req), bit_ch);
            rd(ma, v);
            chk("R7 pending promoted", v, b);
            @(negedge clk);
            chk("R6 pulse one cycle", 32'(pin), 0);

            wr(ca, 32'h7D);
            rd(0, v);
            chk("R4 zero keeps flag", v, bit_ch);
            wr(ca, 32'hFD);
            rd(0, v);
            chk("R4 one clears flag", v, 0);
            chk("R9 irq cleared", 32'(irq), 0);

            step(b, 1'b1);
            rd(0, v);
            chk("R3 second match", v, bit_ch);
            wr(ca, 32'hFD);
            step(b, 1'b1);
            rd(0, v);
            chk("R7 fires once", v, 0);

            // toggle mode, irq on, dma off: 0x40 | (0x5<<2)
            wr(ca, 32'h00);
            wr(ma, a);
            wr(ca, 32'h54);
            step(a, 1'b1);
            chk("R5 toggle high", 32'(pin), bit_ch);
            chk("R9 dma disabled", 32'(dma_req), 0);
            chk("R9 irq on", 32'(irq), 1);
            step(a + 32'd1, 1'b1);
            chk("R5 holds", 32'(pin), bit_ch);
            wr(ma, b);
            step(b, 1'b1);
            chk("R5 toggle low", 32'(pin), 0);
            wr(ma, c);
            step(c, 1'b1);
            chk("R5 toggle high again", 32'(pin), bit_ch);

            // mode 0: pin cleared, buffers dropped, matches ignored
            wr(ma, a);
            wr(ca, 32'h80);
            chk("R8 pin cleared", 32'(pin), 0);
            rd(0, v);
            chk("R4 flag cleared by mode0 write", v, 0);
            wr(ma, c);
            step(c, 1'b1);
            rd(0, v);
            chk("R8 off ignores match", v, 0);
            wr(ca, 32'h3C);
            step(a, 1'b1);
            rd(0, v);
            chk("R8 discarded value", v, 0);
            step(c, 1'b1);
            rd(0, v);
            chk("R8 rearm after off", v, bit_ch);
            chk("R9 irq disabled", 32'(irq), 0);
            wr(ca, 32'h80);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule